// File: doc/BRIEF.md
# STN Frame Rate Control Dither

This block converts a 4-bit gray level into a single on/off drive bit for each pixel of a passive-matrix (STN) panel. Intermediate shades come from frame rate control: across a cycle of frames a pixel is switched on in a share of frames that matches its level. This is a duty-cycle effect, not an analog drive. The on/off placement comes from a bank of programmable 16-bit pattern words, one word per gray level. A bit is picked from the word using the sum of a free-running frame count and the pixel's horizontal position. Neighbouring columns therefore read different bits, and every column's choice moves on each frame, so adjacent pixels do not switch together.

Software loads the pattern words into a staging bank at any time. The staged words are copied to the active bank only on a frame-start strobe, so no frame ever mixes old and new patterns. When the controller drives a TFT panel, the enable input is low and the block is bypassed. The drive bit is then held at 0 and frame strobes have no effect.

Top module: `frc_dither`

## Requirements
- R1: While rst_ni is low, and after it is released until the first pixel, vld_o and drv_o are 0. The frame count is 0 and every staged and active pattern word is all zeros, so levels 1 to 14 drive 0 until patterns are loaded.
- R2: A cycle with pix_vld_i high gives vld_o high on the next cycle, with drv_o holding that pixel's result. A cycle with pix_vld_i low gives vld_o = 0 and drv_o = 0 on the next cycle.
- R3: In STN mode (stn_en_i = 1), for levels 1 to 14, drv_o equals bit ((F + x) mod 16) of the active pattern word for that level. F is the frame count and x is pix_x_i. Bit 0 is the least significant bit of the word.
- R4: Level 0 always drives 0 and level 15 always drives 1 in STN mode, whatever their pattern words hold.
- R5: Each frame_start_i cycle in STN mode increments the 4-bit frame count, which wraps from 15 to 0. A pixel presented in the same cycle as the strobe still uses the count and patterns from before the strobe.
- R6: A write (pat_we_i with pat_sel_i selecting the level and pat_wdata_i holding the word) lands in the staging bank only. All staged words become active at the next frame_start_i in STN mode. A write in the same cycle as a strobe waits for the strobe after that one.
- R7: With stn_en_i = 0, drv_o is 0 for every pixel. Frame strobes neither advance the count nor copy the staged words, but writes are still staged.
- R8: Only x mod 16 affects the result. Pixels 16 columns apart in the same frame with the same level give the same drive bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stn_en_i | input | 1 | 1 = STN panel (dither active), 0 = TFT bypass |
| frame_start_i | input | 1 | One-cycle strobe at the start of each frame |
| pix_vld_i | input | 1 | Pixel enable for this cycle |
| pix_lvl_i | input | 4 | Pixel gray level, 0 to 15 |
| pix_x_i | input | 11 | Pixel horizontal coordinate |
| pat_we_i | input | 1 | Pattern word write strobe |
| pat_sel_i | input | 4 | Gray level whose pattern word is written |
| pat_wdata_i | input | 16 | Pattern word to stage |
| vld_o | output | 1 | Drive bit valid, one cycle after pix_vld_i |
| drv_o | output | 1 | Pixel on/off drive value |

## Verification
A wrong frame count or a missed wrap moves the selected bit along the pattern word. This shows up on the first pixel after the faulty strobe that reads a non-uniform pattern. A staging fault, such as a copy at the wrong time or a write going straight to the active bank, only appears on the first pixel that reads the affected level after the next strobe, or before it. The bench therefore samples each level both before and after strobes. A fault in the level 0 and 15 overrides or in the bypass gating shows on the very next pixel that uses those levels or that mode. For that reason the patterns for levels 0 and 15 are loaded with the opposite of their forced values.

// File: rtl/frc_dither_pkg.sv
package frc_dither_pkg;
  localparam int unsigned LEVEL_W    = 4;
  localparam int unsigned NUM_LEVELS = 1 << LEVEL_W;
  localparam int unsigned PAT_W      = NUM_LEVELS;
  localparam int unsigned IDX_W      = $clog2(PAT_W);

  typedef logic [LEVEL_W-1:0] lvl_t;
  typedef logic [PAT_W-1:0]   pat_t;
  typedef logic [IDX_W-1:0]   idx_t;

  localparam lvl_t LVL_OFF = '0;
  localparam lvl_t LVL_ON  = '1;
endpackage

// File: rtl/frc_frame_counter.sv
module frc_frame_counter
  import frc_dither_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  output idx_t cnt_o
);
  idx_t cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (adv_i) cnt_q <= cnt_q + idx_t'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/frc_pattern_bank.sv
module frc_pattern_bank
  import frc_dither_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  lvl_t sel_i,
  input  pat_t wdata_i,
  input  logic commit_i,
  input  lvl_t rd_sel_i,
  output pat_t rd_word_o
);
  pat_t stage_q [NUM_LEVELS];
  pat_t act_q   [NUM_LEVELS];

  for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_word
    logic hit;
    assign hit = we_i && (sel_i == lvl_t'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[g] <= '0;
        act_q[g]   <= '0;
      end else begin
        // copy takes the staged word from before any same-cycle write
        if (commit_i) act_q[g]   <= stage_q[g];
        if (hit)      stage_q[g] <= wdata_i;
      end
    end
  end

  assign rd_word_o = act_q[rd_sel_i];
endmodule

// File: rtl/frc_bit_select.sv
module frc_bit_select
  import frc_dither_pkg::*;
(
  input  lvl_t lvl_i,
  input  idx_t x_mod_i,
  input  idx_t cnt_i,
  input  pat_t word_i,
  output logic bit_o
);
  idx_t idx;

  assign idx = cnt_i + x_mod_i;

  always_comb begin
    if (lvl_i == LVL_OFF)     bit_o = 1'b0;
    else if (lvl_i == LVL_ON) bit_o = 1'b1;
    else                      bit_o = word_i[idx];
  end
endmodule

// File: rtl/frc_dither.sv
module frc_dither
  import frc_dither_pkg::*;
#(
  parameter int unsigned X_W = 11
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           stn_en_i,
  input  logic           frame_start_i,
  input  logic           pix_vld_i,
  input  logic [LEVEL_W-1:0] pix_lvl_i,
  input  logic [X_W-1:0] pix_x_i,
  input  logic           pat_we_i,
  input  logic [LEVEL_W-1:0] pat_sel_i,
  input  logic [PAT_W-1:0]   pat_wdata_i,
  output logic           vld_o,
  output logic           drv_o
);
  localparam logic [X_W-1:0] X_MOD = X_W'(PAT_W);

  logic commit;
  idx_t frame_cnt;
  idx_t x_mod;
  pat_t word;
  logic sel_bit;
  logic vld_q, drv_q;

  assign commit = frame_start_i && stn_en_i;
  assign x_mod  = idx_t'(pix_x_i % X_MOD);

  frc_frame_counter u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (commit),
    .cnt_o (frame_cnt)
  );

  frc_pattern_bank u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (pat_we_i),
    .sel_i    (pat_sel_i),
    .wdata_i  (pat_wdata_i),
    .commit_i (commit),
    .rd_sel_i (pix_lvl_i),
    .rd_word_o(word)
  );

  frc_bit_select u_sel (
    .lvl_i  (pix_lvl_i),
    .x_mod_i(x_mod),
    .cnt_i  (frame_cnt),
    .word_i (word),
    .bit_o  (sel_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      drv_q <= 1'b0;
    end else begin
      vld_q <= pix_vld_i;
      drv_q <= pix_vld_i && stn_en_i && sel_bit;
    end
  end

  assign vld_o = vld_q;
  assign drv_o = drv_q;
endmodule

// File: rtl/frc_dither_chk.sv
module frc_dither_chk
  import frc_dither_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic stn_en_i,
  input logic frame_start_i,
  input logic pix_vld_i,
  input lvl_t pix_lvl_i,
  input logic vld_o,
  input logic drv_o,
  input idx_t frame_cnt
);
  assert_vld_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_vld_i |=> vld_o);

  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_vld_i |=> (!vld_o && !drv_o));

  assert_level_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_vld_i && stn_en_i && pix_lvl_i == LVL_OFF) |=> !drv_o);

  assert_level_on_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_vld_i && stn_en_i && pix_lvl_i == LVL_ON) |=> drv_o);

  assert_bypass_dark_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stn_en_i |=> !drv_o);

  assert_count_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_i && stn_en_i) |=> frame_cnt == idx_t'($past(frame_cnt) + idx_t'(1)));

  assert_count_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(frame_start_i && stn_en_i) |=> $stable(frame_cnt));
endmodule

bind frc_dither frc_dither_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .stn_en_i     (stn_en_i),
  .frame_start_i(frame_start_i),
  .pix_vld_i    (pix_vld_i),
  .pix_lvl_i    (pix_lvl_i),
  .vld_o        (vld_o),
  .drv_o        (drv_o),
  .frame_cnt    (frame_cnt)
);

// File: tb/frc_dither_test.sv
module frc_dither_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        stn_en_i = 1'b0;
  logic        frame_start_i = 1'b0;
  logic        pix_vld_i = 1'b0;
  logic [3:0]  pix_lvl_i = '0;
  logic [10:0] pix_x_i = '0;
  logic        pat_we_i = 1'b0;
  logic [3:0]  pat_sel_i = '0;
  logic [15:0] pat_wdata_i = '0;
  logic        vld_o, drv_o;

  frc_dither uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .stn_en_i(stn_en_i),
    .frame_start_i(frame_start_i), .pix_vld_i(pix_vld_i),
    .pix_lvl_i(pix_lvl_i), .pix_x_i(pix_x_i), .pat_we_i(pat_we_i),
    .pat_sel_i(pat_sel_i), .pat_wdata_i(pat_wdata_i),
    .vld_o(vld_o), .drv_o(drv_o)
  );

  always #10 clk_i = ~clk_i;

  typedef struct {
    int    due;
    bit    vld;
    bit    drv;
    string tag;
  } item_t;

  item_t       exp_q[$];
  int          cyc = 0;
  int          checks = 0;
  int          errors = 0;
  bit   [15:0] stage_m [16];
  bit   [15:0] act_m   [16];
  int          fcnt_m = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit model_bit(bit en, bit [3:0] lvl, bit [10:0] x);
    if (!en) return 1'b0;
    if (lvl == 4'd0) return 1'b0;
    if (lvl == 4'd15) return 1'b1;
    return act_m[lvl][(fcnt_m + int'(x)) % 16];
  endfunction

  task automatic step(input bit en, input bit vld, input bit [3:0] lvl,
                      input bit [10:0] x, input bit fs, input bit we,
                      input bit [3:0] ws, input bit [15:0] wd, input string tag);
    item_t it;
    @(negedge clk_i);
    stn_en_i = en; pix_vld_i = vld; pix_lvl_i = lvl; pix_x_i = x;
    frame_start_i = fs; pat_we_i = we; pat_sel_i = ws; pat_wdata_i = wd;
    it.due = cyc + 1;
    it.vld = vld;
    it.drv = vld ? model_bit(en, lvl, x) : 1'b0;
    it.tag = tag;
    exp_q.push_back(it);
    if (fs && en) begin
      for (int i = 0; i < 16; i++) act_m[i] = stage_m[i];
      fcnt_m = (fcnt_m + 1) % 16;
    end
    if (we) stage_m[ws] = wd;
  endtask

  task automatic pix(input bit [3:0] lvl, input bit [10:0] x, input string tag);
    step(1'b1, 1'b1, lvl, x, 1'b0, 1'b0, 4'd0, 16'd0, tag);
  endtask

  task automatic wr(input bit [3:0] ws, input bit [15:0] wd, input string tag);
    step(1'b1, 1'b0, 4'd0, 11'd0, 1'b0, 1'b1, ws, wd, tag);
  endtask

  task automatic frame(input string tag);
    step(1'b1, 1'b0, 4'd0, 11'd0, 1'b1, 1'b0, 4'd0, 16'd0, tag);
  endtask

  // monitor: compare every due cycle against the scoreboard
  always @(negedge clk_i) begin
    item_t got;
    if (rst_ni) begin
      while (exp_q.size() > 0 && exp_q[0].due == cyc) begin
        got = exp_q.pop_front();
        check(vld_o == got.vld, {got.tag, " vld_o"}, int'(vld_o), int'(got.vld));
        check(drv_o == got.drv, {got.tag, " drv_o"}, int'(drv_o), int'(got.drv));
      end
    end
  end

  task automatic summary;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog R2 actual=%0d expected=%0d", cyc, 0);
    summary();
  end

  initial begin
    for (int i = 0; i < 16; i++) begin stage_m[i] = '0; act_m[i] = '0; end
    repeat (3) @(negedge clk_i);
    check(vld_o == 1'b0, "R1 reset vld_o", int'(vld_o), 0);
    check(drv_o == 1'b0, "R1 reset drv_o", int'(drv_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(vld_o == 1'b0 && drv_o == 1'b0, "R1 after release", int'({vld_o, drv_o}), 0);

    // reset patterns are zero
    pix(4'd5, 11'd3, "R1");
    pix(4'd15, 11'd0, "R4");
    pix(4'd0, 11'd7, "R4");
    step(1'b1, 1'b0, 4'd0, 11'd0, 1'b0, 1'b0, 4'd0, 16'd0, "R2");

    // staged write not yet active
    wr(4'd3, 16'hA5C3, "R6");
    for (int x = 0; x < 16; x++) pix(4'd3, 11'(x), "R6");
    frame("R5");
    for (int x = 0; x < 16; x++) pix(4'd3, 11'(x), "R3");
    for (int k = 0; k < 16; k++) pix(4'd3, 11'(16 + k), "R8");
    for (int k = 0; k < 4; k++) pix(4'd3, 11'(1024 + 16 * k + k), "R8");

    // overrides against inverse patterns
    wr(4'd0, 16'hFFFF, "R4");
    wr(4'd15, 16'h0000, "R4");
    frame("R4");
    for (int x = 0; x < 16; x += 3) begin
      pix(4'd0, 11'(x), "R4");
      pix(4'd15, 11'(x), "R4");
    end

    // write concurrent with strobe waits one more frame
    wr(4'd7, 16'h0001, "R6");
    step(1'b1, 1'b0, 4'd0, 11'd0, 1'b1, 1'b1, 4'd9, 16'h00FF, "R6");
    for (int x = 0; x < 16; x++) pix(4'd9, 11'(x), "R6");
    for (int x = 0; x < 16; x++) pix(4'd7, 11'(x), "R3");

    // bypass: dark output, strobes ignored, writes staged
    for (int x = 0; x < 4; x++)
      step(1'b0, 1'b1, 4'd15, 11'(x), 1'b0, 1'b0, 4'd0, 16'd0, "R7");
    step(1'b0, 1'b1, 4'd7, 11'd2, 1'b1, 1'b0, 4'd0, 16'd0, "R7");
    step(1'b0, 1'b0, 4'd0, 11'd0, 1'b1, 1'b1, 4'd11, 16'h8001, "R7");
    step(1'b0, 1'b0, 4'd0, 11'd0, 1'b1, 1'b0, 4'd0, 16'd0, "R7");
    for (int x = 0; x < 16; x++) pix(4'd7, 11'(x), "R7");
    for (int x = 0; x < 16; x++) pix(4'd11, 11'(x), "R7");
    frame("R7");
    for (int x = 0; x < 16; x++) pix(4'd11, 11'(x), "R7");
    for (int x = 0; x < 16; x++) pix(4'd9, 11'(x), "R6");

    // wrap, and pixel in the strobe cycle
    for (int f = 0; f < 16; f++) begin
      step(1'b1, 1'b1, 4'd7, 11'(f), 1'b1, 1'b0, 4'd0, 16'd0, "R5");
      pix(4'd7, 11'(f), "R5");
    end
    for (int x = 0; x < 16; x++) pix(4'd7, 11'(x), "R5");

    // duty over 16 frames at a fixed column
    wr(4'd9, 16'b0101_1011_0110_1101, "R3");
    frame("R3");
    for (int f = 0; f < 16; f++) begin
      pix(4'd9, 11'd5, "R3");
      pix(4'd9, 11'd6, "R3");
      frame("R3");
    end

    // mixed traffic
    for (int n = 0; n < 400; n++) begin
      step(($urandom_range(0, 15) != 0), ($urandom_range(0, 3) != 0),
           4'($urandom_range(0, 15)), 11'($urandom_range(0, 2047)),
           ($urandom_range(0, 19) == 0), ($urandom_range(0, 9) == 0),
           4'($urandom_range(0, 15)), 16'($urandom), "R3");
    end

    repeat (3) step(1'b1, 1'b0, 4'd0, 11'd0, 1'b0, 1'b0, 4'd0, 16'd0, "R2");
    @(negedge clk_i);
    @(negedge clk_i);
    check(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
    summary();
  end
endmodule